// File: doc/BRIEF.md
# Host Serial Port Selection Lock Controller

This block decides which of two host serial ports, I2C or SPI, owns a pair of shared pins. After every reset it watches the SPI slave-select line, active low, through a synchronizer. While that line stays high, I2C is the active port. Three synchronized high-to-low transitions switch the choice to SPI. Pulses can come from a host that drives the line as a plain I/O pin. They can also come from three SPI writes to an address that no register occupies: such writes toggle the line and do nothing else here.

The choice is then frozen by a write to the 8-bit configuration register. When I2C is the active port, the write freezes the choice only if it sets the lock bit. When SPI is the active port, any write freezes it. A frozen choice ignores further slave-select activity. It survives a hardware reset taken in low-power mode. Only a power-down, or a hardware reset taken in normal mode, clears it.

The block also holds the enable of the high-speed data capture port, which works alongside I2C. That enable is low after every kind of reset.

Top module: `ssel_port_lock`

## Requirements
- R1: After `rst_n`, `port_sel` is 0 (I2C; 1 means SPI), `port_locked` is 0 and `hsdc_en` is 0.
- R2: While `ss_n_raw` stays high and no lock has occurred, `port_sel` stays 0.
- R3: A falling edge of `ss_n_raw` counts after two synchronizer stages plus one register. The third counted edge sets `port_sel` to 1 on the third rising clock edge after the fall. After one or two edges `port_sel` is still 0.
- R4: With `port_sel`=0 and no lock, an `i2c_cfg_wr` whose data has bit 1 set raises `port_locked` on the next clock. The same write with bit 1 clear does not lock.
- R5: With `port_sel`=1 and no lock, any `spi_cfg_wr` raises `port_locked` on the next clock, whatever its data.
- R6: A configuration write from the port that is not selected changes neither `port_locked` nor `hsdc_en`.
- R7: Once `port_locked` is 1, slave-select falling edges no longer change `port_sel`.
- R8: A `hw_reset` with `low_power`=1 while locked keeps `port_locked` and `port_sel`, and clears `hsdc_en`.
- R9: A `pwr_down` pulse, or a `hw_reset` with `low_power`=0, returns all outputs to the R1 state on the next clock and restarts the edge count.
- R10: An `i2c_cfg_wr` accepted while `port_sel`=0 loads `hsdc_en` from data bit 0 on the next clock. SPI writes never change `hsdc_en`.
- R11: The edge count saturates at three. Falling edges beyond the third leave `port_sel`=1 and do not lock or touch `hsdc_en`, so writes to an unused SPI address have no further effect.
- R12: A `hw_reset` with `low_power`=1 while unlocked clears the edge count and all outputs, like R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, power-on |
| hw_reset | input | 1 | Synchronous hardware reset request, one-cycle pulse |
| low_power | input | 1 | 1 = low-power mode, 0 = normal mode |
| pwr_down | input | 1 | Synchronous power-down pulse, clears everything |
| ss_n_raw | input | 1 | Unsynchronized SPI slave-select level, active low |
| spi_cfg_wr | input | 1 | Configuration register write strobe from SPI |
| spi_cfg_data | input | 8 | Data of the SPI configuration write |
| i2c_cfg_wr | input | 1 | Configuration register write strobe from I2C |
| i2c_cfg_data | input | 8 | Data of the I2C configuration write (bit 1 lock, bit 0 capture enable) |
| port_sel | output | 1 | Active port: 0 I2C, 1 SPI |
| port_locked | output | 1 | Selection is frozen |
| hsdc_en | output | 1 | High-speed data capture port enable |

## Verification
A configuration write or a reset pulse acts on the first rising edge that samples it. A slave-select fall needs three edges: two synchronizer stages plus the counter register. The bench drives inputs 1 time unit after a rising edge and samples just before the next one. For R3 it checks that `port_sel` is still 0 after the second edge past the fall and is 1 after the third. For random operations it waits several idle cycles before it compares the outputs with its own model, so every result has settled by then.

// File: rtl/ssel_pkg.sv
package ssel_pkg;

    typedef enum logic {
        PORT_I2C = 1'b0,
        PORT_SPI = 1'b1
    } port_e;

    typedef struct packed {
        logic locked;
        logic hsdc;
    } lock_state_t;

endpackage

// File: rtl/ssel_sync.sv
module ssel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = din;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], din};
        end
    endgenerate

    always_comb begin
        prev_d = sh_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '1;
            prev_q <= 1'b1;
        end else begin
            sh_q   <= sh_d;
            prev_q <= prev_d;
        end
    end

    assign level = sh_q[LAST];
    assign fall  = prev_q & ~sh_q[LAST];

    // R3: an edge is flagged only for a single cycle
    p_fall_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/ssel_toggle_cnt.sv
module ssel_toggle_cnt #(
    parameter int TOGGLES = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         hold,
    input  logic                         fall,
    output logic [$clog2(TOGGLES+1)-1:0] cnt,
    output logic                         reached
);
    localparam int CNT_W = $clog2(TOGGLES + 1);
    localparam logic [CNT_W-1:0] TOP = CNT_W'(TOGGLES);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (fall && !hold && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt     = cnt_q;
    assign reached = (cnt_q == TOP);

    // R11: count never passes the target
    p_cnt_sat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    // R11: a full count is only left through a clear
    p_cnt_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == TOP) && !clr |=> cnt_q == TOP);
    // R7: hold freezes the count
    p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold && !clr |=> $stable(cnt_q));
endmodule

// File: rtl/ssel_lock_ctl.sv
module ssel_lock_ctl
    import ssel_pkg::*;
#(
    parameter int CFG_W    = 8,
    parameter int LOCK_BIT = 1,
    parameter int HSDC_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_reset,
    input  logic             low_power,
    input  logic             pwr_down,
    input  port_e            sel,
    input  logic             spi_cfg_wr,
    input  logic [CFG_W-1:0] spi_cfg_data,
    input  logic             i2c_cfg_wr,
    input  logic [CFG_W-1:0] i2c_cfg_data,
    output logic             clr_cnt,
    output logic             hold_cnt,
    output logic             locked,
    output logic             hsdc_en
);
    lock_state_t st_d, st_q;
    logic        i2c_ok, lock_now, any_rst;

    always_comb begin
        any_rst  = pwr_down | hw_reset;
        clr_cnt  = pwr_down | (hw_reset & (!low_power | !st_q.locked));
        i2c_ok   = i2c_cfg_wr & (sel == PORT_I2C) & !any_rst;
        lock_now = !st_q.locked & !any_rst &
                   ((i2c_ok & i2c_cfg_data[LOCK_BIT]) |
                    (spi_cfg_wr & (sel == PORT_SPI)));
        hold_cnt = st_q.locked | lock_now;

        st_d = st_q;
        if (clr_cnt) begin
            st_d = '0;
        end else if (any_rst) begin
            st_d.hsdc = 1'b0;
        end else begin
            if (i2c_ok)   st_d.hsdc   = i2c_cfg_data[HSDC_BIT];
            if (lock_now) st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked  = st_q.locked;
    assign hsdc_en = st_q.hsdc;

    // R1/R9: capture enable is low after any reset request
    p_hsdc_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down || hw_reset |=> !hsdc_en);
    // R9: full clear from power-down or normal-mode reset
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down || (hw_reset && !low_power) |=> !locked);
    // R8: low-power reset keeps the lock
    p_keep_lp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked && hw_reset && low_power && !pwr_down |=> locked);
    // R5: SPI write locks when SPI is selected
    p_spi_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && sel == PORT_SPI && spi_cfg_wr && !hw_reset && !pwr_down
        |=> locked);
    // R4: I2C write with lock bit locks when I2C is selected
    p_i2c_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !locked && sel == PORT_I2C && i2c_cfg_wr && i2c_cfg_data[LOCK_BIT]
        && !hw_reset && !pwr_down |=> locked);
    // R7: selection stable while locked and no clear
    p_sel_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked && !clr_cnt |=> $stable(sel));
    // R10: SPI-only writes do not touch the capture enable
    p_spi_no_hsdc_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cfg_wr && !i2c_cfg_wr && !hw_reset && !pwr_down |=> $stable(hsdc_en));
endmodule

// File: rtl/ssel_port_lock.sv
module ssel_port_lock
    import ssel_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TOGGLES     = 3,
    parameter int CFG_W       = 8,
    parameter int LOCK_BIT    = 1,
    parameter int HSDC_BIT    = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_reset,
    input  logic             low_power,
    input  logic             pwr_down,
    input  logic             ss_n_raw,
    input  logic             spi_cfg_wr,
    input  logic [CFG_W-1:0] spi_cfg_data,
    input  logic             i2c_cfg_wr,
    input  logic [CFG_W-1:0] i2c_cfg_data,
    output logic             port_sel,
    output logic             port_locked,
    output logic             hsdc_en
);
    localparam int CNT_W = $clog2(TOGGLES + 1);

    logic             ss_level, ss_fall;
    logic             clr_cnt, hold_cnt, reached;
    logic [CNT_W-1:0] cnt;
    port_e            sel;

    ssel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ss_n_raw),
        .level (ss_level),
        .fall  (ss_fall)
    );

    ssel_toggle_cnt #(.TOGGLES(TOGGLES)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_cnt),
        .hold    (hold_cnt),
        .fall    (ss_fall),
        .cnt     (cnt),
        .reached (reached)
    );

    assign sel = reached ? PORT_SPI : PORT_I2C;

    ssel_lock_ctl #(
        .CFG_W    (CFG_W),
        .LOCK_BIT (LOCK_BIT),
        .HSDC_BIT (HSDC_BIT)
    ) u_lock (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_reset     (hw_reset),
        .low_power    (low_power),
        .pwr_down     (pwr_down),
        .sel          (sel),
        .spi_cfg_wr   (spi_cfg_wr),
        .spi_cfg_data (spi_cfg_data),
        .i2c_cfg_wr   (i2c_cfg_wr),
        .i2c_cfg_data (i2c_cfg_data),
        .clr_cnt      (clr_cnt),
        .hold_cnt     (hold_cnt),
        .locked       (port_locked),
        .hsdc_en      (hsdc_en)
    );

    assign port_sel = sel;

    // R2: with the line held high the count cannot move
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ss_level && $past(ss_level) && !clr_cnt |=> $stable(cnt));
endmodule

// File: tb/test_ssel_port_lock.sv
module test_ssel_port_lock;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_reset = 1'b0, low_power = 1'b0, pwr_down = 1'b0;
    logic       ss_n_raw = 1'b1;
    logic       spi_cfg_wr = 1'b0, i2c_cfg_wr = 1'b0;
    logic [7:0] spi_cfg_data = '0, i2c_cfg_data = '0;
    logic       port_sel, port_locked, hsdc_en;

    int n_tests = 0, n_fail = 0;
    int m_cnt = 0;
    bit m_lock = 0, m_hsdc = 0;

    always #(CLK_P/2) clk = ~clk;

    ssel_port_lock i_ssel_port_lock (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .low_power(low_power),
        .pwr_down(pwr_down), .ss_n_raw(ss_n_raw), .spi_cfg_wr(spi_cfg_wr),
        .spi_cfg_data(spi_cfg_data), .i2c_cfg_wr(i2c_cfg_wr),
        .i2c_cfg_data(i2c_cfg_data), .port_sel(port_sel),
        .port_locked(port_locked), .hsdc_en(hsdc_en)
    );

    function automatic bit exp_sel();
        return m_cnt == 3;
    endfunction

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(bit act, bit exp, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic chk_all(string tag);
        chk(port_sel, exp_sel(), {tag, " sel"});
        chk(port_locked, m_lock, {tag, " lock"});
        chk(hsdc_en, m_hsdc, {tag, " hsdc"});
    endtask

    task automatic toggle();
        ss_n_raw = 1'b0; tick(3);
        ss_n_raw = 1'b1; tick(4);
        if (!m_lock && m_cnt < 3) m_cnt++;
    endtask

    task automatic i2c_wr(logic [7:0] d);
        i2c_cfg_data = d; i2c_cfg_wr = 1'b1; tick(1);
        i2c_cfg_wr = 1'b0; tick(2);
        if (m_cnt < 3) begin
            m_hsdc = d[0];
            if (!m_lock && d[1]) m_lock = 1;
        end
    endtask

    task automatic spi_wr(logic [7:0] d);
        spi_cfg_data = d; spi_cfg_wr = 1'b1; tick(1);
        spi_cfg_wr = 1'b0; tick(2);
        if (m_cnt == 3 && !m_lock) m_lock = 1;
    endtask

    task automatic hwrst(bit lp);
        low_power = lp; hw_reset = 1'b1; tick(1);
        hw_reset = 1'b0; tick(2);
        m_hsdc = 0;
        if (!lp || !m_lock) begin m_cnt = 0; m_lock = 0; end
    endtask

    task automatic pdown();
        pwr_down = 1'b1; tick(1);
        pwr_down = 1'b0; tick(2);
        m_cnt = 0; m_lock = 0; m_hsdc = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk_all("R1 reset");

        tick(20);
        chk_all("R2 idle high");

        toggle(); toggle();
        chk(port_sel, 1'b0, "R3 two edges still I2C");
        // third fall: exact latency
        ss_n_raw = 1'b0;
        tick(2);
        chk(port_sel, 1'b0, "R3 two clocks after fall");
        tick(1);
        chk(port_sel, 1'b1, "R3 three clocks after fall");
        ss_n_raw = 1'b1; tick(4);
        m_cnt = 3;

        toggle(); toggle();
        chk_all("R11 extra edges saturate");

        i2c_wr(8'h03);
        chk_all("R6 I2C write ignored under SPI");

        spi_cfg_data = 8'h00; spi_cfg_wr = 1'b1; tick(1);
        spi_cfg_wr = 1'b0;
        chk(port_locked, 1'b1, "R5 SPI write locks next clock");
        m_lock = 1; tick(2);

        hwrst(1'b1);
        chk_all("R8 low-power reset keeps SPI lock");

        hwrst(1'b0);
        chk_all("R9 normal reset clears");

        i2c_wr(8'h01);
        chk_all("R4 no lock without bit 1");
        chk(hsdc_en, 1'b1, "R10 hsdc loaded from bit 0");
        spi_wr(8'hFF);
        chk_all("R6 SPI write ignored under I2C");

        i2c_cfg_data = 8'h03; i2c_cfg_wr = 1'b1; tick(1);
        i2c_cfg_wr = 1'b0;
        chk(port_locked, 1'b1, "R4 I2C lock next clock");
        m_lock = 1; m_hsdc = 1; tick(2);

        for (int k = 0; k < 4; k++) toggle();
        chk_all("R7 locked I2C ignores edges");

        hwrst(1'b1);
        chk_all("R8 low-power reset keeps I2C lock, hsdc off");

        pdown();
        chk_all("R9 power-down clears");

        toggle(); toggle();
        hwrst(1'b1);
        chk_all("R12 unlocked low-power reset clears");
        toggle(); toggle();
        chk(port_sel, 1'b0, "R12 count restarted");
        toggle();
        chk(port_sel, 1'b1, "R12 three fresh edges select SPI");

        hwrst(1'b0);
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 99);
            if (op < 40)      toggle();
            else if (op < 60) i2c_wr(8'($urandom));
            else if (op < 78) spi_wr(8'($urandom));
            else if (op < 90) hwrst(1'b1);
            else if (op < 97) hwrst(1'b0);
            else              pdown();
            chk_all($sformatf("R3/R4/R5/R7/R10 random op %0d", it));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule